// File: doc/BRIEF.md
# Single-Master Bus Decoder with Registered Return Select

This block joins one bus master, usually a processor, to a small set of slaves such as on-chip memory and peripheral register banks. The top bits of the master's address choose a slave. A read or write strobe is forwarded only to that slave. Address and write data are broadcast to every slave. The read data and the ready-count sent back to the master come from the slave that was chosen when the last request was accepted. That choice is held in a register, not decoded again from the live address, so the decode compare stays off the return path. The scheme relies on each slave holding its last read data on its output until a new request replaces it.

Only one transaction is in flight at a time, and requests complete in issue order. Each slave has a pipeline level. A new request is forwarded only while the ready-count of the currently selected slave is below the issue limit for that level. If the limit is not met, the strobe is withheld and the master must present the request again. An address outside the mapped range reaches no slave. It selects a null source that returns zero data and a zero ready-count, so the master never waits on it.

Top module: `sbus_decoder`

## Requirements
- R1: After a synchronous active-low reset, the master sees read data of all zeros and a ready-count of 0, whatever the slaves drive.
- R2: The slave index is the top SEL_BITS bits of the master address. The default is address bits [15:13]. An accepted read or write strobe goes only to the slave with that index, at bit position equal to the index in the strobe vectors. All other slaves see inactive strobes.
- R3: A slave index of N_SLV or above is unmapped, with defaults 5, 6 and 7. A request to it reaches no slave. Once it is accepted, the master sees read data 0 and ready-count 0.
- R4: The return select changes only in a cycle where a strobe is accepted. In idle or blocked cycles the returned data and ready-count keep following the previously selected slave, even when the address moves to another slave.
- R5: Read data to the master is the read data of the slave selected by the most recently accepted request. It appears from the cycle after acceptance.
- R6: The ready-count to the master is the ready-count of the slave named by the registered select, not of the slave the current address decodes to.
- R7: A request is accepted only when the selected slave's ready-count is below its issue limit. The limit is the slave's pipeline level, or 1 when the level is 0. With the default levels, slaves 0 to 4 have limits 1, 1, 2, 3 and 1. When nothing is mapped, every request is accepted.
- R8: The slave-side address and write data equal the master's address and write data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_rdata | output | DATA_W | Read data returned to the master |
| m_rdy_cnt | output | CNT_W | Ready-count returned to the master |
| s_addr | output | ADDR_W | Address broadcast to all slaves |
| s_wdata | output | DATA_W | Write data broadcast to all slaves |
| s_rd | output | N_SLV | Per-slave read strobes |
| s_wr | output | N_SLV | Per-slave write strobes |
| s_rdata | input | N_SLV*DATA_W | Slave read data, slave i at bits [i*DATA_W +: DATA_W] |
| s_rdy_cnt | input | N_SLV*CNT_W | Slave ready-counts, slave i at bits [i*CNT_W +: CNT_W] |

## Verification
The first pattern is a read to each slave in turn with every ready-count at zero, which shows whether strobes land on the right index and whether the return mux follows the newly accepted slave. Idle cycles that move the address to other slaves while the slave outputs change tell a registered select apart from a live decode. Ready-counts placed exactly at, and one below, each slave's issue limit separate correct gating from off-by-one gating, and unmapped addresses show the zero return. A long random mix of reads, writes, addresses and ready-counts is compared every cycle against a behavioural model that keeps only the index of the last accepted slave.

// File: rtl/sbus_dec_pkg.sv
// Package: shared helpers for the single-master bus decoder.
// Assumes pipeline levels are small unsigned values encoded in CNT_W bits.
package sbus_dec_pkg;

    // Issue limit for a pipeline level: level 0 behaves as level 1.
    function automatic int unsigned issue_limit(input int unsigned level);
        return (level == 0) ? 1 : level;
    endfunction

endpackage

// File: rtl/sbus_addr_decode.sv
// Module: sbus_addr_decode
// Turns the slave-select field of the address into a slave index and a
// hit flag. This is pure combinational compare logic.
// Assumes N_SLV <= 2**SEL_BITS; indices at or above N_SLV are unmapped.
module sbus_addr_decode #(
    parameter int SEL_BITS = 3,
    parameter int N_SLV    = 5
) (
    input  logic [SEL_BITS-1:0] sel_field,
    output logic [SEL_BITS-1:0] dec_idx,
    output logic                dec_hit
);

    localparam int unsigned MAP_LIMIT = N_SLV;

    // Index passthrough and range compare for the hit flag.
    always_comb begin
        dec_idx = sel_field;
        dec_hit = (32'(sel_field) < MAP_LIMIT);
    end

endmodule

// File: rtl/sbus_sel_track.sv
// Module: sbus_sel_track
// Holds the registered return select and decides whether a new request
// may be accepted, based on the ready-count of the currently selected
// slave and that slave's issue limit.
// Assumes one master and one transaction in flight; the select changes
// only when a strobe is accepted.
module sbus_sel_track
    import sbus_dec_pkg::*;
#(
    parameter int                     IDX_W    = 3,
    parameter int                     N_SLV    = 5,
    parameter int                     CNT_W    = 2,
    parameter logic [N_SLV*CNT_W-1:0] PIPE_LVL = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [IDX_W-1:0]       dec_idx,
    input  logic                   dec_hit,
    input  logic [N_SLV*CNT_W-1:0] s_rdy_cnt,
    output logic [IDX_W-1:0]       sel_idx,
    output logic                   sel_hit,
    output logic                   allow,
    output logic                   issue
);

    logic [IDX_W-1:0] sel_q;
    logic             hit_q;
    logic [N_SLV-1:0] slv_ok;

    // Per-slave readiness against its own compile-time issue limit.
    for (genvar g = 0; g < N_SLV; g++) begin : g_lim
        localparam int unsigned LIM = issue_limit(int'(PIPE_LVL[g*CNT_W +: CNT_W]));
        assign slv_ok[g] = (32'(s_rdy_cnt[g*CNT_W +: CNT_W]) < LIM);
    end

    // Accept gate: the ready flag of the registered slave, or free when nothing is mapped.
    always_comb begin
        allow = 1'b1;
        for (int i = 0; i < N_SLV; i++) begin
            if (hit_q && (sel_q == IDX_W'(i))) allow = slv_ok[i];
        end
        issue = req && allow;
    end

    // Return-select register, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            hit_q <= 1'b0;
        end else if (issue) begin
            sel_q <= dec_idx;
            hit_q <= dec_hit;
        end
    end

    assign sel_idx = sel_q;
    assign sel_hit = hit_q;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(sel_q) && $stable(hit_q)));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_hit) |=> (hit_q && sel_q == $past(dec_idx)));

    assert_unmapped_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_q |-> allow);

endmodule

// File: rtl/sbus_ret_mux.sv
// Module: sbus_ret_mux
// AND-OR multiplexer that returns read data and ready-count of the slave
// named by the registered select. An unmapped select yields zeros.
// Assumes slaves hold read data stable until their next request.
module sbus_ret_mux #(
    parameter int IDX_W  = 3,
    parameter int N_SLV  = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        sel_idx,
    input  logic                    sel_hit,
    input  logic [N_SLV*DATA_W-1:0] s_rdata,
    input  logic [N_SLV*CNT_W-1:0]  s_rdy_cnt,
    output logic [DATA_W-1:0]       m_rdata,
    output logic [CNT_W-1:0]        m_rdy_cnt
);

    logic [N_SLV-1:0] pick;

    // One-hot pick from the registered select.
    for (genvar g = 0; g < N_SLV; g++) begin : g_pick
        assign pick[g] = sel_hit && (sel_idx == IDX_W'(g));
    end

    // AND-OR reduction over all slaves.
    always_comb begin
        m_rdata   = '0;
        m_rdy_cnt = '0;
        for (int i = 0; i < N_SLV; i++) begin
            m_rdata   = m_rdata   | ({DATA_W{pick[i]}} & s_rdata[i*DATA_W +: DATA_W]);
            m_rdy_cnt = m_rdy_cnt | ({CNT_W{pick[i]}}  & s_rdy_cnt[i*CNT_W +: CNT_W]);
        end
    end

    assert_pick_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

    assert_null_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hit |-> (m_rdata == '0 && m_rdy_cnt == '0));

endmodule

// File: rtl/sbus_decoder.sv
// Module: sbus_decoder (top)
// Single-master interconnect: decodes upper address bits to one slave,
// gates the strobes by the selected slave's ready-count, and returns data
// through a mux steered by a select registered at request time.
// Assumes one master, in-order completion and slaves that hold read data.
module sbus_decoder #(
    parameter int                     ADDR_W   = 16,
    parameter int                     DATA_W   = 32,
    parameter int                     SEL_BITS = 3,
    parameter int                     N_SLV    = 5,
    parameter int                     CNT_W    = 2,
    parameter logic [N_SLV*CNT_W-1:0] PIPE_LVL = {2'd0, 2'd3, 2'd2, 2'd1, 2'd1}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       m_addr,
    input  logic [DATA_W-1:0]       m_wdata,
    input  logic                    m_rd,
    input  logic                    m_wr,
    output logic [DATA_W-1:0]       m_rdata,
    output logic [CNT_W-1:0]        m_rdy_cnt,
    output logic [ADDR_W-1:0]       s_addr,
    output logic [DATA_W-1:0]       s_wdata,
    output logic [N_SLV-1:0]        s_rd,
    output logic [N_SLV-1:0]        s_wr,
    input  logic [N_SLV*DATA_W-1:0] s_rdata,
    input  logic [N_SLV*CNT_W-1:0]  s_rdy_cnt
);

    localparam int IDX_W = SEL_BITS;

    logic [IDX_W-1:0] dec_idx;
    logic             dec_hit;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_hit;
    logic             allow;
    logic             issue;

    sbus_addr_decode #(
        .SEL_BITS (SEL_BITS),
        .N_SLV    (N_SLV)
    ) u_dec (
        .sel_field (m_addr[ADDR_W-1 -: SEL_BITS]),
        .dec_idx   (dec_idx),
        .dec_hit   (dec_hit)
    );

    sbus_sel_track #(
        .IDX_W    (IDX_W),
        .N_SLV    (N_SLV),
        .CNT_W    (CNT_W),
        .PIPE_LVL (PIPE_LVL)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (m_rd || m_wr),
        .dec_idx   (dec_idx),
        .dec_hit   (dec_hit),
        .s_rdy_cnt (s_rdy_cnt),
        .sel_idx   (sel_idx),
        .sel_hit   (sel_hit),
        .allow     (allow),
        .issue     (issue)
    );

    sbus_ret_mux #(
        .IDX_W  (IDX_W),
        .N_SLV  (N_SLV),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_idx   (sel_idx),
        .sel_hit   (sel_hit),
        .s_rdata   (s_rdata),
        .s_rdy_cnt (s_rdy_cnt),
        .m_rdata   (m_rdata),
        .m_rdy_cnt (m_rdy_cnt)
    );

    // Broadcast address and write data to every slave.
    assign s_addr  = m_addr;
    assign s_wdata = m_wdata;

    // Per-slave strobe steering: only the decoded slave, only when accepted.
    for (genvar g = 0; g < N_SLV; g++) begin : g_stb
        logic hit_me;
        assign hit_me  = allow && dec_hit && (dec_idx == IDX_W'(g));
        assign s_rd[g] = m_rd && hit_me;
        assign s_wr[g] = m_wr && hit_me;
    end

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_rd | s_wr));

    assert_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_rd || m_wr) && !allow) |-> (s_rd == '0 && s_wr == '0));

    assert_unmapped_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (s_rd == '0 && s_wr == '0));

    assert_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && issue && dec_hit) |-> (s_rd != '0));

endmodule

// File: tb/tb_sbus_decoder.sv
`timescale 1ns/1ps
module tb_sbus_decoder;

    localparam int N  = 5;
    localparam int DW = 32;
    localparam int CW = 2;
    localparam int AW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     m_addr = '0;
    logic [DW-1:0]     m_wdata = '0;
    logic              m_rd = 1'b0;
    logic              m_wr = 1'b0;
    logic [DW-1:0]     m_rdata;
    logic [CW-1:0]     m_rdy_cnt;
    logic [AW-1:0]     s_addr;
    logic [DW-1:0]     s_wdata;
    logic [N-1:0]      s_rd;
    logic [N-1:0]      s_wr;
    logic [N*DW-1:0]   s_rdata = '0;
    logic [N*CW-1:0]   s_rdy_cnt = '0;

    int checks = 0;
    int errors = 0;
    int msel = -1;          // model: index of last accepted slave, -1 = none/unmapped
    bit last_issued = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sbus_decoder dut (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rd(m_rd), .m_wr(m_wr), .m_rdata(m_rdata), .m_rdy_cnt(m_rdy_cnt),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_rd(s_rd), .s_wr(s_wr),
        .s_rdata(s_rdata), .s_rdy_cnt(s_rdy_cnt)
    );

    // Issue limits from R7: slaves 0..4 -> 1,1,2,3,1.
    function automatic int lim(input int i);
        case (i)
            2: return 2;
            3: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic rd, input logic wr,
                        input logic [N*CW-1:0] rdys);
        int dec;
        bit hit, alw;
        logic [N-1:0] exp_stb;
        logic [DW-1:0] exp_rd;
        logic [CW-1:0] exp_cnt;
        string stag, rtag;
        @(negedge clk);
        m_addr = a; m_rd = rd; m_wr = wr; m_wdata = $urandom;
        s_rdy_cnt = rdys;
        for (int i = 0; i < N; i++) s_rdata[i*DW +: DW] = $urandom;
        #2;
        dec = int'(a[AW-1 -: 3]);
        hit = (dec < N);
        alw = (msel < 0) ? 1'b1 : (int'(rdys[msel*CW +: CW]) < lim(msel));
        exp_stb = (alw && hit) ? (N'(1) << dec) : '0;
        exp_rd  = (msel < 0) ? '0 : s_rdata[msel*DW +: DW];
        exp_cnt = (msel < 0) ? '0 : rdys[msel*CW +: CW];
        stag = !alw ? "R7" : (!hit ? "R3" : "R2");
        rtag = (msel < 0) ? "R3" : (last_issued ? "R5" : "R4");
        chk({stag, " s_rd"}, 64'(s_rd), 64'(rd ? exp_stb : '0));
        chk({stag, " s_wr"}, 64'(s_wr), 64'(wr ? exp_stb : '0));
        chk({rtag, " m_rdata"}, 64'(m_rdata), 64'(exp_rd));
        chk((msel < 0) ? "R3 m_rdy_cnt" : "R6 m_rdy_cnt", 64'(m_rdy_cnt), 64'(exp_cnt));
        chk("R8 s_addr", 64'(s_addr), 64'(a));
        chk("R8 s_wdata", 64'(s_wdata), 64'(m_wdata));
        @(posedge clk);
        last_issued = (rd || wr) && alw;
        if (last_issued) msel = hit ? dec : -1;
    endtask

    function automatic logic [AW-1:0] adr(input int s);
        return {3'(s), 13'($urandom)};
    endfunction

    function automatic logic [N*CW-1:0] cnt_at(input int s, input int v);
        logic [N*CW-1:0] r = '0;
        r[s*CW +: CW] = CW'(v);
        return r;
    endfunction

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) s_rdata[i*DW +: DW] = 32'hA5A5_0000 + i;
        s_rdy_cnt = '1;
        #2;
        chk("R1 m_rdata", 64'(m_rdata), 64'h0);   // R1
        chk("R1 m_rdy_cnt", 64'(m_rdy_cnt), 64'h0);
        chk("R1 s_rd", 64'(s_rd), 64'h0);
        s_rdy_cnt = '0;
        // each slave in turn, all ready
        for (int s = 0; s < N; s++) begin
            step(adr(s), 1'b1, 1'b0, '0);
            step(adr(s), 1'b0, 1'b0, '0);
        end
        // hold: address wanders while idle (R4)
        step(adr(2), 1'b1, 1'b0, '0);
        for (int k = 0; k < 8; k++) step(adr(k), 1'b0, 1'b0, N*CW'($urandom));
        // unmapped then return zero (R3)
        step(adr(6), 1'b1, 1'b0, '0);
        step(adr(1), 1'b0, 1'b0, '1);
        step(adr(7), 1'b0, 1'b1, '0);
        // gating on limits (R7)
        step(adr(3), 1'b1, 1'b0, '0);
        step(adr(0), 1'b1, 1'b0, cnt_at(3, 3));  // blocked
        step(adr(0), 1'b0, 1'b1, cnt_at(3, 3));  // blocked
        step(adr(0), 1'b1, 1'b0, cnt_at(3, 2));  // accepted
        step(adr(2), 1'b1, 1'b0, cnt_at(0, 1));  // blocked
        step(adr(2), 1'b1, 1'b0, '0);            // accepted
        step(adr(4), 1'b0, 1'b1, cnt_at(2, 2));  // blocked
        step(adr(4), 1'b0, 1'b1, cnt_at(2, 1));  // accepted
        step(adr(1), 1'b1, 1'b0, cnt_at(4, 1));  // blocked (level 0 -> limit 1)
        step(adr(1), 1'b1, 1'b0, '0);
        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] op = 2'($urandom);
            step(16'($urandom), op[0], op[1] & ($urandom_range(0, 3) == 0),
                 N*CW'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule